// File: doc/BRIEF.md
# Dual-Segment Base-Limit Address Translator

This block turns a virtual address into a physical address. The program sees one unbroken virtual range. The block splits that range across two physical regions. A host programs four registers through a narrow write port: a base and a length for each region. The first region serves virtual addresses below its length. The second region serves the addresses that follow, so the first length is subtracted before the second base is added. The two lengths together define the whole legal range. Any address outside that range is reported as a fault.

Each request carries a valid strobe and a virtual address. The result comes back one clock later as a valid strobe, a physical address and a fault flag. Requests may arrive every cycle. A register write and a request may arrive in the same cycle. In that case the request is translated with the register values as they were before the write.

Top module: `seg_xlat_top`

## Requirements
- R1: After reset all four registers read as zero. The response strobe is low, and every request faults until the registers are written.
- R2: A virtual address strictly below length A returns the virtual address plus base A, modulo 2^AW, with the fault flag low.
- R3: A virtual address at or above length A, and below length A plus length B, returns the virtual address minus length A plus base B, modulo 2^AW, with the fault flag low.
- R4: A virtual address at or above length A plus length B raises the fault flag and returns a physical address of zero.
- R5: The sum of the two lengths is formed one bit wider than the address. An address is therefore accepted whenever it is below the true sum, even when that sum exceeds 2^AW - 1.
- R6: The response strobe goes high exactly one cycle after each cycle with the request strobe high. Back-to-back requests give back-to-back responses in order.
- R7: A register write in the same cycle as a request does not affect that request. It applies from the next request onward.
- R8: In any cycle with the response strobe low, the physical address and the fault flag are both zero.
- R9: Register selection codes are: 0 = base A, 1 = length A, 2 = base B, 3 = length B. When the write enable is low, the data and select inputs have no effect.
- R10: When length A is zero, every in-range address is translated through the second region, starting at base B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 2 | Register select (R9 encoding) |
| cfg_data_i | input | AW | Register write data |
| req_valid_i | input | 1 | Request strobe |
| req_vaddr_i | input | AW | Virtual address |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr_o | output | AW | Physical address, zero on a fault or when idle |
| rsp_fault_o | output | 1 | Address outside both regions |

## Verification
Two functions can land in the same cycle: a register write and a translation request. The bench provokes this by asserting the write enable together with the request strobe. It first changes length B so that an address which faulted before becomes legal. The scoreboard expects the old result, a fault, for the request issued in that cycle. It expects the new mapping for an identical request one cycle later. The overflow case is judged with lengths whose sum exceeds 2^AW. The top address must then translate, not fault.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);

  typedef enum logic [SEL_W-1:0] {
    SEL_BASE_A = 2'd0,
    SEL_LEN_A  = 2'd1,
    SEL_BASE_B = 2'd2,
    SEL_LEN_B  = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/seg_xlat_regs.sv
module seg_xlat_regs
  import seg_xlat_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [AW-1:0]    data_i,
  output logic [AW-1:0]    base_a_o,
  output logic [AW-1:0]    len_a_o,
  output logic [AW-1:0]    base_b_o,
  output logic [AW-1:0]    len_b_o
);

  logic [NUM_REGS-1:0][AW-1:0] reg_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q[g] <= '0;
      end else if (we_i && (sel_i == SEL_W'(g))) begin
        reg_q[g] <= data_i;
      end
    end
  end

  assign base_a_o = reg_q[SEL_BASE_A];
  assign len_a_o  = reg_q[SEL_LEN_A];
  assign base_b_o = reg_q[SEL_BASE_B];
  assign len_b_o  = reg_q[SEL_LEN_B];

endmodule

// File: rtl/seg_xlat_calc.sv
module seg_xlat_calc #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] base_a_i,
  input  logic [AW-1:0] len_a_i,
  input  logic [AW-1:0] base_b_i,
  input  logic [AW-1:0] len_b_i,
  output logic [AW-1:0] paddr_o,
  output logic          fault_o
);

  localparam int unsigned SW = AW + 1;

  logic [SW-1:0] span;
  logic          hit_a;
  logic          hit_b;
  logic [AW-1:0] pa_a;
  logic [AW-1:0] off_b;
  logic [AW-1:0] pa_b;

  // widened sum: no wrap into a small legal range
  assign span  = {1'b0, len_a_i} + {1'b0, len_b_i};
  assign hit_a = vaddr_i < len_a_i;
  assign hit_b = !hit_a && ({1'b0, vaddr_i} < span);

  assign pa_a  = vaddr_i + base_a_i;
  assign off_b = vaddr_i - len_a_i;
  assign pa_b  = off_b + base_b_i;

  always_comb begin
    paddr_o = '0;
    fault_o = 1'b0;
    if (hit_a) begin
      paddr_o = pa_a;
    end else if (hit_b) begin
      paddr_o = pa_b;
    end else begin
      fault_o = 1'b1;
    end
  end

endmodule

// File: rtl/seg_xlat_rsp.sv
module seg_xlat_rsp #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] paddr_i,
  input  logic          fault_i,
  output logic          valid_o,
  output logic [AW-1:0] paddr_o,
  output logic          fault_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      paddr_o <= '0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      paddr_o <= valid_i ? paddr_i : '0;
      fault_o <= valid_i && fault_i;
    end
  end

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
  import seg_xlat_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_data_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_vaddr_i,
  output logic          rsp_valid_o,
  output logic [AW-1:0] rsp_paddr_o,
  output logic          rsp_fault_o
);

  logic [AW-1:0] base_a;
  logic [AW-1:0] len_a;
  logic [AW-1:0] base_b;
  logic [AW-1:0] len_b;
  logic [AW-1:0] xl_paddr;
  logic          xl_fault;

  seg_xlat_regs #(.AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .data_i   (cfg_data_i),
    .base_a_o (base_a),
    .len_a_o  (len_a),
    .base_b_o (base_b),
    .len_b_o  (len_b)
  );

  seg_xlat_calc #(.AW(AW)) u_calc (
    .vaddr_i  (req_vaddr_i),
    .base_a_i (base_a),
    .len_a_i  (len_a),
    .base_b_i (base_b),
    .len_b_i  (len_b),
    .paddr_o  (xl_paddr),
    .fault_o  (xl_fault)
  );

  seg_xlat_rsp #(.AW(AW)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .paddr_i (xl_paddr),
    .fault_i (xl_fault),
    .valid_o (rsp_valid_o),
    .paddr_o (rsp_paddr_o),
    .fault_o (rsp_fault_o)
  );

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] req_vaddr_i,
  input logic          rsp_valid_o,
  input logic [AW-1:0] rsp_paddr_o,
  input logic          rsp_fault_o,
  input logic [AW-1:0] base_a,
  input logic [AW-1:0] len_a,
  input logic [AW-1:0] base_b,
  input logic [AW-1:0] len_b
);

  logic          armed_q;
  logic          pv_q;
  logic [AW-1:0] pa_q, pba_q, pla_q, pbb_q, plb_q;
  logic [AW:0]   psum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pv_q    <= 1'b0;
      pa_q    <= '0;
      pba_q   <= '0;
      pla_q   <= '0;
      pbb_q   <= '0;
      plb_q   <= '0;
    end else begin
      armed_q <= 1'b1;
      pv_q    <= req_valid_i;
      pa_q    <= req_vaddr_i;
      pba_q   <= base_a;
      pla_q   <= len_a;
      pbb_q   <= base_b;
      plb_q   <= len_b;
    end
  end

  assign psum = {1'b0, pla_q} + {1'b0, plb_q};

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !rsp_valid_o);

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (rsp_valid_o == pv_q));

  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_paddr_o == '0 && !rsp_fault_o));

  p_fault_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && rsp_valid_o) |-> (rsp_fault_o == ({1'b0, pa_q} >= psum)));

  // register values sampled with the request, so R7 is covered too
  p_seg_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && rsp_valid_o && pa_q < pla_q) |-> (rsp_paddr_o == pa_q + pba_q));

  p_seg_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && rsp_valid_o && pa_q >= pla_q && !rsp_fault_o)
      |-> (rsp_paddr_o == pa_q - pla_q + pbb_q));

endmodule

bind seg_xlat_top seg_xlat_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o),
  .base_a      (base_a),
  .len_a       (len_a),
  .base_b      (base_b),
  .len_b       (len_b)
);

// File: tb/tb_seg_xlat_top.sv
module tb_seg_xlat_top;

  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_sel_i = '0;
  logic [AW-1:0] cfg_data_i = '0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_vaddr_i = '0;
  logic          rsp_valid_o;
  logic [AW-1:0] rsp_paddr_o;
  logic          rsp_fault_o;

  always #10 clk = ~clk;

  seg_xlat_top #(.AW(AW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_data_i  (cfg_data_i),
    .req_valid_i (req_valid_i),
    .req_vaddr_i (req_vaddr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_fault_o (rsp_fault_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench copy of the register values, codes per R9
  logic [AW-1:0] m_reg [4];

  logic [AW-1:0] q_pa[$];
  logic          q_ft[$];
  string         q_tag[$];

  task automatic check(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic expect_xl(input logic [AW-1:0] va, input string tag);
    logic [AW:0]   sum;
    logic [AW-1:0] pa;
    logic          ft;
    sum = {1'b0, m_reg[1]} + {1'b0, m_reg[3]};
    if (va < m_reg[1]) begin
      pa = va + m_reg[0]; ft = 1'b0;
    end else if ({1'b0, va} < sum) begin
      pa = va - m_reg[1] + m_reg[2]; ft = 1'b0;
    end else begin
      pa = '0; ft = 1'b1;
    end
    q_pa.push_back(pa);
    q_ft.push_back(ft);
    q_tag.push_back(tag);
  endtask

  // one cycle: optional write, optional request; expectation taken before the write (R7)
  task automatic cycle(input bit we, input logic [1:0] sel, input logic [AW-1:0] data,
                       input bit rv, input logic [AW-1:0] va, input string tag);
    @(negedge clk);
    if (rv) expect_xl(va, tag);
    if (we) m_reg[sel] = data;
    cfg_we_i    = we;
    cfg_sel_i   = sel;
    cfg_data_i  = data;
    req_valid_i = rv;
    req_vaddr_i = va;
    @(negedge clk);
    cfg_we_i    = 1'b0;
    req_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data);
    cycle(1'b1, sel, data, 1'b0, '0, "");
  endtask

  task automatic rq(input logic [AW-1:0] va, input string tag);
    cycle(1'b0, 2'd0, '0, 1'b1, va, tag);
  endtask

  // back-to-back requests, no idle cycle between them (R6)
  task automatic burst(input logic [AW-1:0] va0, input logic [AW-1:0] va1, input string tag);
    @(negedge clk);
    expect_xl(va0, tag);
    req_valid_i = 1'b1;
    req_vaddr_i = va0;
    @(negedge clk);
    expect_xl(va1, tag);
    req_vaddr_i = va1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  // monitor samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_ni && !done) begin
      if (rsp_valid_o) begin
        if (q_pa.size() == 0) begin
          check(1'b0, "R6", "response with nothing expected");
        end else begin
          logic [AW-1:0] epa;
          logic          eft;
          string         etag;
          epa  = q_pa.pop_front();
          eft  = q_ft.pop_front();
          etag = q_tag.pop_front();
          check(rsp_paddr_o == epa && rsp_fault_o == eft, etag,
                $sformatf("paddr=%h fault=%0b exp paddr=%h fault=%0b",
                          rsp_paddr_o, rsp_fault_o, epa, eft));
        end
      end else begin
        check(rsp_paddr_o == '0 && !rsp_fault_o, "R8",
              $sformatf("idle paddr=%h fault=%0b exp 0/0", rsp_paddr_o, rsp_fault_o));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid_o == 1'b0, "R1", $sformatf("valid=%0b exp 0", rsp_valid_o));
    rst_ni = 1'b1;
    rq(32'h0000_0000, "R1");
    rq(32'h0000_1234, "R1");

    // R9: program through the select codes
    wr(2'd0, 32'h1000_0000);
    wr(2'd1, 32'h0000_4000);
    wr(2'd2, 32'h8000_0000);
    wr(2'd3, 32'h0000_2000);
    rq(32'h0000_0000, "R2");
    rq(32'h0000_3FFF, "R2");
    rq(32'h0000_4000, "R3");
    rq(32'h0000_5FFF, "R3");
    rq(32'h0000_6000, "R4");
    rq(32'hFFFF_FFFF, "R4");
    burst(32'h0000_0100, 32'h0000_4100, "R6");

    // R9: select and data with write enable low change nothing
    cycle(1'b0, 2'd3, 32'h0000_FFFF, 1'b0, '0, "");
    rq(32'h0000_6000, "R9");

    // R7: same-cycle write does not touch the request
    cycle(1'b1, 2'd3, 32'h0000_3000, 1'b1, 32'h0000_6000, "R7");
    rq(32'h0000_6000, "R7");

    // R5: true length sum above 2^AW
    wr(2'd1, 32'hF000_0000);
    wr(2'd3, 32'h2000_0000);
    wr(2'd2, 32'h0000_0100);
    rq(32'hFFFF_FFF0, "R5");
    rq(32'h0000_0010, "R5");
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd3, 32'h0000_0000);
    rq(32'hFFFF_FFFE, "R5");
    rq(32'hFFFF_FFFF, "R5");

    // R10: empty first region
    wr(2'd1, 32'h0000_0000);
    wr(2'd3, 32'h0000_0800);
    rq(32'h0000_0000, "R10");
    rq(32'h0000_07FF, "R10");
    rq(32'h0000_0800, "R10");

    repeat (3) @(negedge clk);
    check(q_pa.size() == 0, "R6", $sformatf("pending=%0d exp 0", q_pa.size()));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule